// File: doc/BRIEF.md
# Nested Priority Interrupt Vectoring Unit

This unit sits beside a DSP program sequencer and decides which of six interrupt slots is serviced next. Each slot has a fixed rank and a fixed vector address. Slot 0 is the external high-priority pin. Slots 1 and 2 are serial port 0 transmit and receive. Slots 3 and 4 are shared: serial port 1 transmit and receive, or two further external pins, selected by one mode input. Slot 5 is the timer. A rising edge on any slot line sets a pending bit. The winning pending request is turned into a one-cycle take strobe and a vector address.

The unit keeps a stack of the levels now in service. A routine can be interrupted only by a request of strictly higher rank, so service routines nest. When the sequencer signals a return, the stack pops and the previous level comes back into force. Requests that are masked, disabled or outranked stay pending and are taken later in rank order. External pins are brought into the clock domain by a two-flop synchronizer. Events from the serial ports and the timer are already synchronous and go straight to edge detection.

Top module: `dsp_irq_vectorer`

## Requirements
- R1: After reset, `int_take` is 0, `vec_addr` is 0x0000, `cur_lvl` is 6 (idle) and no request is pending.
- R2: A take of slot s drives `vec_addr` = 4*(s+1): slot 0 (external high pin) 0x0004, slot 1 (SP0 transmit) 0x0008, slot 2 (SP0 receive) 0x000C, slot 3 0x0010, slot 4 0x0014, slot 5 (timer) 0x0018. `cur_lvl` then reads s.
- R3: When several eligible requests are pending in the same cycle, the one with the lowest slot number (highest rank) is taken first.
- R4: With `slot_pins_sel`=0, slots 3 and 4 follow `sp1_tx_evt` and `sp1_rx_evt`. With `slot_pins_sel`=1 they follow `pin_irq[1]` and `pin_irq[0]`, and the serial port 1 events have no effect.
- R5: A request is taken only if its slot number is below `cur_lvl`. A request of equal or lower rank waits while a routine is in service.
- R6: A one-cycle `rti` pops the level stack, and `cur_lvl` returns to the previously active level (6 when the stack empties). `rti` with an empty stack leaves `cur_lvl` at 6. No take is issued in a cycle where `rti` is high.
- R7: A masked request (`irq_mask[s]`=1) stays pending and is taken once its mask bit is cleared.
- R8: No take happens while `glob_en`=0 or `entry_ok`=0. Pending requests are kept and are taken when both inputs return to 1.
- R9: `int_take` rises on the 2nd clock edge after an internal event pulse is sampled high. For a pin, it rises on the 4th edge after the pin is sampled high (two synchronizer edges, then latch, then take).
- R10: A pending bit is set only by a rising edge and is cleared by its take. A line held high yields exactly one take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_irq | input | 3 | Asynchronous external pins: bit 2 high-priority pin, bits 1 and 0 for the shared slots |
| sp0_tx_evt | input | 1 | Serial port 0 transmit event |
| sp0_rx_evt | input | 1 | Serial port 0 receive event |
| sp1_tx_evt | input | 1 | Serial port 1 transmit event |
| sp1_rx_evt | input | 1 | Serial port 1 receive event |
| timer_evt | input | 1 | Timer event |
| irq_mask | input | 6 | Per-slot mask, bit s masks slot s |
| glob_en | input | 1 | Global interrupt enable |
| slot_pins_sel | input | 1 | 1: slots 3/4 are driven by pins; 0: by serial port 1 |
| entry_ok | input | 1 | Sequencer can branch to a vector this cycle |
| rti | input | 1 | Return-from-interrupt strobe |
| int_take | output | 1 | One-cycle strobe: an interrupt was taken |
| vec_addr | output | 14 | Vector address of the last take (0x0000 after reset) |
| cur_lvl | output | 3 | In-service slot at stack top, 6 when idle |

## Verification
The hardest state to reach from the ports is a nested stack in which a lower-ranked request has been latched but must be held back, and is released only by a return. The stimulus reaches it in three steps. First it enters the timer routine. Next it nests a serial-port-0 routine on top. It then fires slot 3 while slot 1 is in service and confirms that nothing is taken. After one `rti`, it checks that the level falls back to 5 and that the held slot-3 request is taken on the next cycle. Held-high lines, masked-then-unmasked requests and mode-switched shared slots are driven the same way, each followed by a drain through repeated returns.

// File: rtl/irq_vec_pkg.sv
// Package: shared slot numbering and level constants for the vectoring unit.
// Assumes slot number equals rank, 0 being the highest.
package irq_vec_pkg;
    localparam int NUM_SLOTS = 6;
    localparam int LVL_W     = $clog2(NUM_SLOTS + 1);
    localparam logic [LVL_W-1:0] LVL_IDLE = LVL_W'(NUM_SLOTS);

    typedef enum logic [LVL_W-1:0] {
        SLOT_EXT_HI  = 3'd0,
        SLOT_SP0_TX  = 3'd1,
        SLOT_SP0_RX  = 3'd2,
        SLOT_SHR_A   = 3'd3,
        SLOT_SHR_B   = 3'd4,
        SLOT_TIMER   = 3'd5
    } slot_e;
endpackage

// File: rtl/irq_pin_sync.sv
// Module: multi-stage synchronizer for asynchronous request pins.
// Assumes STAGES >= 1; output lags input by STAGES clock edges.
module irq_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: shift each pin one flop further into the clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= '0;
                else if (g == 0) chain[g] <= async_in;
                else chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_latch.sv
// Module: rising-edge detector plus pending flags, one per slot.
// Assumes inputs are synchronous; clear and a fresh edge in the same
// cycle leave the flag set so no edge is lost.
module irq_edge_latch #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] clr,
    output logic [N-1:0] pend
);
    logic [N-1:0] prev;
    logic [N-1:0] rise;

    assign rise = lines & ~prev;

    // Purpose: remember last line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lines;
    end

    // Purpose: set flags on rising edges, drop them when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | rise;
    end

    p_pend_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~rise) != '0) |=> ((pend & $past(clr & ~rise)) == '0))
        else $error("taken request remained pending");
endmodule

// File: rtl/irq_prio_pick.sv
// Module: combinational fixed-rank picker. A slot is eligible when it is
// pending, unmasked, globally enabled and ranked above the current level.
// Assumes slot number equals rank (0 highest).
module irq_prio_pick
    import irq_vec_pkg::*;
#(
    parameter int N = NUM_SLOTS
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     mask,
    input  logic             en,
    input  logic [LVL_W-1:0] cur_lvl,
    output logic             any,
    output logic [LVL_W-1:0] idx,
    output logic [N-1:0]     grant
);
    logic [N-1:0] elig;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_elig
            assign elig[g] = pend[g] & ~mask[g] & en & (LVL_W'(g) < cur_lvl);
        end
    endgenerate

    // Purpose: choose the lowest-numbered eligible slot.
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                any   = 1'b1;
                idx   = LVL_W'(i);
                grant = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/irq_level_stack.sv
// Module: LIFO of in-service levels. Top reads IDLE when empty.
// Assumes push and pop are never high together; pop on empty is ignored.
module irq_level_stack #(
    parameter int DEPTH = 7,
    parameter int LVL_W = 3,
    parameter logic [LVL_W-1:0] IDLE = 3'd6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic [LVL_W-1:0] top_lvl,
    output logic             full,
    output logic             empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LVL_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] count;
    logic [IDX_W-1:0] top_idx;

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign top_idx = IDX_W'(count - CNT_W'(1));
    assign top_lvl = empty ? IDLE : mem[top_idx];

    // Purpose: track stack depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (push && !full)    count <= count + CNT_W'(1);
        else if (pop && !empty)    count <= count - CNT_W'(1);
    end

    // Purpose: write the new level into the next free entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= IDLE;
        end else if (push && !full) begin
            mem[IDX_W'(count)] <= push_lvl;
        end
    end

    p_push_not_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full)
        else $error("push into full level stack");

    p_no_push_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop))
        else $error("push and pop in one cycle");
endmodule

// File: rtl/dsp_irq_vectorer.sv
// Module: top of the nested interrupt vectoring unit. Synchronizes pins,
// muxes shared slots, latches edges, picks the winner, pushes its level
// and emits a registered take strobe with the vector address.
// Assumes the sequencer pulses rti for one cycle per completed routine.
module dsp_irq_vectorer
    import irq_vec_pkg::*;
#(
    parameter int ADDR_W      = 14,
    parameter int VEC_STRIDE  = 4,
    parameter int STACK_DEPTH = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           pin_irq,
    input  logic                 sp0_tx_evt,
    input  logic                 sp0_rx_evt,
    input  logic                 sp1_tx_evt,
    input  logic                 sp1_rx_evt,
    input  logic                 timer_evt,
    input  logic [NUM_SLOTS-1:0] irq_mask,
    input  logic                 glob_en,
    input  logic                 slot_pins_sel,
    input  logic                 entry_ok,
    input  logic                 rti,
    output logic                 int_take,
    output logic [ADDR_W-1:0]    vec_addr,
    output logic [LVL_W-1:0]     cur_lvl
);
    localparam logic [ADDR_W-1:0] VEC_MAX = ADDR_W'(NUM_SLOTS * VEC_STRIDE);

    logic [2:0]           pin_s;
    logic [NUM_SLOTS-1:0] slot_line;
    logic [NUM_SLOTS-1:0] pend;
    logic [NUM_SLOTS-1:0] clr;
    logic [NUM_SLOTS-1:0] grant;
    logic                 pick_any;
    logic [LVL_W-1:0]     pick_idx;
    logic                 take_now;
    logic                 stk_full;
    logic                 stk_empty;
    logic [ADDR_W-1:0]    vec_next;

    irq_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_irq), .sync_out(pin_s)
    );

    // Purpose: map sources onto rank-ordered slot lines, shared slots by mode.
    always_comb begin
        slot_line[SLOT_EXT_HI] = pin_s[2];
        slot_line[SLOT_SP0_TX] = sp0_tx_evt;
        slot_line[SLOT_SP0_RX] = sp0_rx_evt;
        slot_line[SLOT_SHR_A]  = slot_pins_sel ? pin_s[1] : sp1_tx_evt;
        slot_line[SLOT_SHR_B]  = slot_pins_sel ? pin_s[0] : sp1_rx_evt;
        slot_line[SLOT_TIMER]  = timer_evt;
    end

    irq_edge_latch #(.N(NUM_SLOTS)) u_latch (
        .clk(clk), .rst_n(rst_n), .lines(slot_line), .clr(clr), .pend(pend)
    );

    irq_prio_pick #(.N(NUM_SLOTS)) u_pick (
        .pend(pend), .mask(irq_mask), .en(glob_en), .cur_lvl(cur_lvl),
        .any(pick_any), .idx(pick_idx), .grant(grant)
    );

    irq_level_stack #(.DEPTH(STACK_DEPTH), .LVL_W(LVL_W), .IDLE(LVL_IDLE)) u_stack (
        .clk(clk), .rst_n(rst_n), .push(take_now), .push_lvl(pick_idx),
        .pop(rti), .top_lvl(cur_lvl), .full(stk_full), .empty(stk_empty)
    );

    assign take_now = pick_any & entry_ok & ~rti & ~stk_full;
    assign clr      = take_now ? grant : '0;
    assign vec_next = ADDR_W'((32'(pick_idx) + 32'd1) * 32'(VEC_STRIDE));

    // Purpose: register the take strobe and hold the last vector address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_take <= 1'b0;
            vec_addr <= '0;
        end else begin
            int_take <= take_now;
            if (take_now) vec_addr <= vec_next;
        end
    end

    p_vec_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> (vec_addr == ADDR_W'((32'(cur_lvl) + 32'd1) * 32'(VEC_STRIDE))
                      && vec_addr != '0 && vec_addr <= VEC_MAX))
        else $error("vector does not match taken level");

    p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant))
        else $error("more than one slot granted");

    p_preempt_higher_r5: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> (cur_lvl < $past(cur_lvl)))
        else $error("take without strictly higher rank");

    p_rti_restores_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rti && !stk_empty) |=> (cur_lvl > $past(cur_lvl)))
        else $error("return did not lower the service rank");

    p_masked_no_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_take |-> (($past(irq_mask) & (NUM_SLOTS'(1) << cur_lvl)) == '0))
        else $error("masked slot was taken");

    p_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!glob_en || !entry_ok || rti) |=> !int_take)
        else $error("take while gated");
endmodule

// File: tb/dsp_irq_vectorer_tb_top.sv
`timescale 1ns/1ps
module dsp_irq_vectorer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  pin_irq;
    logic        sp0_tx_evt, sp0_rx_evt, sp1_tx_evt, sp1_rx_evt, timer_evt;
    logic [5:0]  irq_mask;
    logic        glob_en, slot_pins_sel, entry_ok, rti;
    logic        int_take;
    logic [13:0] vec_addr;
    logic [2:0]  cur_lvl;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dsp_irq_vectorer dut_i (
        .clk(clk), .rst_n(rst_n), .pin_irq(pin_irq),
        .sp0_tx_evt(sp0_tx_evt), .sp0_rx_evt(sp0_rx_evt),
        .sp1_tx_evt(sp1_tx_evt), .sp1_rx_evt(sp1_rx_evt),
        .timer_evt(timer_evt), .irq_mask(irq_mask), .glob_en(glob_en),
        .slot_pins_sel(slot_pins_sel), .entry_ok(entry_ok), .rti(rti),
        .int_take(int_take), .vec_addr(vec_addr), .cur_lvl(cur_lvl)
    );

    typedef struct packed {
        logic [5:0]  pulse;
        logic [5:0]  mask;
        logic        take;
        logic [13:0] vec;
        logic [2:0]  lvl;
    } vec_t;

    // pulse bit s drives slot s (bit 0 unused: that slot is a pin)
    localparam vec_t TBL [10] = '{
        '{6'b000010, 6'b000000, 1'b1, 14'h0008, 3'd1},
        '{6'b000100, 6'b000000, 1'b1, 14'h000C, 3'd2},
        '{6'b001000, 6'b000000, 1'b1, 14'h0010, 3'd3},
        '{6'b010000, 6'b000000, 1'b1, 14'h0014, 3'd4},
        '{6'b100000, 6'b000000, 1'b1, 14'h0018, 3'd5},
        '{6'b111110, 6'b000000, 1'b1, 14'h0008, 3'd1},
        '{6'b111000, 6'b000000, 1'b1, 14'h0010, 3'd3},
        '{6'b111110, 6'b000110, 1'b1, 14'h0010, 3'd3},
        '{6'b100000, 6'b100000, 1'b0, 14'h0000, 3'd6},
        '{6'b101000, 6'b001000, 1'b1, 14'h0018, 3'd5}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic drive_slots(input logic [5:0] b);
        sp0_tx_evt = b[1];
        sp0_rx_evt = b[2];
        sp1_tx_evt = b[3];
        sp1_rx_evt = b[4];
        timer_evt  = b[5];
    endtask

    task automatic pulse(input logic [5:0] b);
        @(negedge clk) drive_slots(b);
        @(negedge clk) drive_slots(6'b0);
    endtask

    task automatic await_take(input int max, input int ev, input int el, input string req);
        bit seen = 0;
        for (int i = 0; i < max && !seen; i++) begin
            @(negedge clk);
            if (int_take) begin
                seen = 1;
                check(vec_addr == 14'(ev), req, vec_addr, ev);
                check(cur_lvl == 3'(el), req, cur_lvl, el);
            end
        end
        if (!seen) check(1'b0, req, 0, 1);
    endtask

    task automatic expect_quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (int_take) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    task automatic do_rti();
        @(negedge clk) rti = 1'b1;
        @(negedge clk) rti = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        irq_mask = '0; glob_en = 1'b1; entry_ok = 1'b1;
        drive_slots(6'b0); pin_irq = '0;
        for (int i = 0; i < 14; i++) begin
            do_rti();
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        rst_n = 1'b0; pin_irq = '0; drive_slots(6'b0);
        irq_mask = '0; glob_en = 1'b1; slot_pins_sel = 1'b0;
        entry_ok = 1'b1; rti = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(int_take == 1'b0, "R1 take", int_take, 0);
        check(vec_addr == 14'h0, "R1 vec", vec_addr, 0);
        check(cur_lvl == 3'd6, "R1 lvl", cur_lvl, 6);
        @(negedge clk) rst_n = 1'b1;
        expect_quiet(4, "R1 no pending");

        // R2 R3 R7: table walk
        foreach (TBL[k]) begin
            @(negedge clk) irq_mask = TBL[k].mask;
            pulse(TBL[k].pulse);
            @(negedge clk);
            check(int_take == TBL[k].take, "R2/R3 table take", int_take, TBL[k].take);
            if (TBL[k].take) begin
                check(vec_addr == TBL[k].vec, "R2 table vec", vec_addr, TBL[k].vec);
                check(cur_lvl == TBL[k].lvl, "R3 table lvl", cur_lvl, TBL[k].lvl);
            end
            drain();
            check(cur_lvl == 3'd6, "R6 drained", cur_lvl, 6);
        end

        // R9: pin latency, 4th edge
        @(negedge clk) pin_irq[2] = 1'b1;
        repeat (3) @(negedge clk);
        check(int_take == 1'b0, "R9 pin early", int_take, 0);
        @(negedge clk);
        check(int_take == 1'b1, "R9 pin take", int_take, 1);
        check(vec_addr == 14'h0004, "R2 pin vec", vec_addr, 4);
        drain();

        // R5 R6: nesting
        pulse(6'b100000);
        await_take(4, 'h18, 5, "R5 timer");
        pulse(6'b000010);
        await_take(4, 'h08, 1, "R5 nest");
        pulse(6'b001000);
        expect_quiet(6, "R5 lower waits");
        do_rti();
        check(cur_lvl == 3'd5, "R6 restore", cur_lvl, 5);
        check(int_take == 1'b0, "R6 no take on rti", int_take, 0);
        await_take(3, 'h10, 3, "R6 held release");
        pulse(6'b001000);
        expect_quiet(6, "R5 equal waits");
        drain();
        do_rti();
        check(cur_lvl == 3'd6, "R6 empty pop", cur_lvl, 6);

        // R7: masked stays pending
        @(negedge clk) irq_mask = 6'b000100;
        pulse(6'b000100);
        expect_quiet(6, "R7 masked");
        @(negedge clk) irq_mask = '0;
        await_take(3, 'h0C, 2, "R7 unmasked");
        drain();

        // R8: gates
        @(negedge clk) glob_en = 1'b0;
        pulse(6'b000010);
        expect_quiet(6, "R8 glob_en");
        @(negedge clk) glob_en = 1'b1;
        await_take(3, 'h08, 1, "R8 glob_en release");
        drain();
        @(negedge clk) entry_ok = 1'b0;
        pulse(6'b010000);
        expect_quiet(6, "R8 entry_ok");
        @(negedge clk) entry_ok = 1'b1;
        await_take(3, 'h14, 4, "R8 entry_ok release");
        drain();

        // R10: held line gives one take
        @(negedge clk) sp0_rx_evt = 1'b1;
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (int_take) cnt++;
        end
        check(cnt == 1, "R10 held line", cnt, 1);
        do_rti();
        expect_quiet(5, "R10 no retrigger");
        drain();

        // R4: shared slots to pins
        @(negedge clk) slot_pins_sel = 1'b1;
        pulse(6'b011000);
        expect_quiet(6, "R4 sp1 ignored");
        @(negedge clk) pin_irq[1] = 1'b1;
        await_take(6, 'h10, 3, "R4 pin slot3");
        drain();
        @(negedge clk) pin_irq[0] = 1'b1;
        await_take(6, 'h14, 4, "R4 pin slot4");
        drain();
        @(negedge clk) slot_pins_sel = 1'b0;
        expect_quiet(4, "R4 mode back");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule